// File: doc/BRIEF.md
# Atomic Compare-and-Exchange Unit

This block carries out a single compare-and-exchange against one memory word over a simple request/acknowledge bus that has a lock line. The caller provides four things: an accumulator value, a source value, a word address and an operand width of 8, 16 or 32 bits. The unit then performs a locked read of the word and compares it with the accumulator at the chosen width. After that it always issues a locked write to the same word and finally drops the lock.

If the compare succeeds, the source value is stored in the addressed bytes. If it fails, the bytes just read are written back unchanged. In both cases every locked read is paired with a locked write. When the operation finishes, the unit returns the following:

- the zero flag;
- the carry, parity, half-carry (borrow out of bit 3), sign and overflow flags, computed as the accumulator minus the memory value;
- an accumulator update with a write-enable that fires only on a failed compare;
- a one-cycle completion pulse.

The unit accepts a new request only when it is idle.

Top module: `cas_unit`

## Requirements
- R1: The compare uses only the low 8, 16 or 32 bits of the accumulator and of the memory word. Width code 0 selects 8 bits, code 1 selects 16 bits and code 2 selects 32 bits. Bits above the selected width have no effect on the result.
- R2: When the masked values are equal, flag_zf is 1 and the written data carries the source operand in the selected bytes. Memory bytes above the selected width keep their old value.
- R3: When the masked values differ, flag_zf is 0 and the word is written back with exactly the value that was read, so memory is unchanged.
- R4: Every operation makes exactly one read request followed by exactly one write request, including on a failed compare. bus_lock is high whenever bus_rd or bus_wr is high, and it falls only in the cycle after the write acknowledge.
- R5: bus_be is 4'b0001 for width code 0, 4'b0011 for code 1 and 4'b1111 for code 2. Data sits in the low lanes.
- R6: acc_we is 1 exactly on a failed compare. In that case acc_out holds the memory value in the selected low bits and the original accumulator bits above them. On a match, acc_out equals the accumulator as given.
- R7: The flags follow from D = accumulator − memory at the selected width:
  - flag_cf is the borrow out of the top bit;
  - flag_sf is the top bit of D;
  - flag_pf is 1 when the low byte of D has an even number of ones;
  - flag_af is the borrow out of bit 3;
  - flag_of is set when the signed difference does not fit the width.
- R8: done is a single-cycle pulse. It rises on the fifth rising edge after the accepting edge, given a memory that acknowledges one cycle after each request. Results are valid while done is high.
- R9: req_ready is low from acceptance until the unit is idle again. A request presented during that time causes no bus activity and changes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted on this edge |
| req_size | input | 2 | Width code: 0=8, 1=16, 2=32 bits |
| req_acc | input | 32 | Accumulator value |
| req_src | input | 32 | Source operand |
| req_addr | input | ADDR_W | Word address |
| bus_lock | output | 1 | Locked-sequence indicator |
| bus_rd | output | 1 | Read request |
| bus_wr | output | 1 | Write request |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 32 | Write data |
| bus_be | output | 4 | Byte enables for the write |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| bus_ack | input | 1 | Acknowledge for the current request |
| acc_out | output | 32 | Updated accumulator |
| acc_we | output | 1 | Accumulator write-enable, high with done on mismatch |
| flag_zf | output | 1 | Zero flag (compare equal) |
| flag_cf | output | 1 | Carry (borrow) flag |
| flag_pf | output | 1 | Parity flag |
| flag_af | output | 1 | Half-carry flag |
| flag_sf | output | 1 | Sign flag |
| flag_of | output | 1 | Overflow flag |
| done | output | 1 | Completion pulse |

## Verification
Take the accepting edge as edge zero. The read request is acknowledged at edge one and the read data is captured at edge two. The compare result is latched at edge three, the write is acknowledged at edge four, and done, the flags and the accumulator update appear after edge five.

The bench drives inputs and samples outputs on falling edges. It counts rising edges from acceptance and checks that done is low after edge four, high after edge five and low again after edge six. It compares every result only in the done cycle. It inspects memory and the request counters only after done.

A sweep covers all three widths with 256 operand pairs each, and the upper bits are deliberately mismatched. Further directed cases cover a request presented while busy.

// File: rtl/cas_pkg.sv
package cas_pkg;

  localparam int unsigned DW  = 32;
  localparam int unsigned BEW = DW / 8;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2
  } size_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_B:    return 32'h0000_00FF;
      SZ_H:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [BEW-1:0] size_be(input logic [1:0] sz);
    case (sz)
      SZ_B:    return 4'b0001;
      SZ_H:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [DW-1:0] merge_low(input logic [DW-1:0] hi_src,
                                              input logic [DW-1:0] lo_src,
                                              input logic [1:0] sz);
    logic [DW-1:0] m;
    m = size_mask(sz);
    return (hi_src & ~m) | (lo_src & m);
  endfunction

  function automatic logic top_bit(input logic [DW-1:0] v, input logic [1:0] sz);
    case (sz)
      SZ_B:    return v[7];
      SZ_H:    return v[15];
      default: return v[31];
    endcase
  endfunction

  function automatic flags_t cmp_flags(input logic [DW-1:0] a,
                                       input logic [DW-1:0] d,
                                       input logic [1:0] sz);
    logic [DW-1:0] m, am, dm, diff;
    logic [DW:0]   full;
    logic [4:0]    nib;
    flags_t        f;
    m    = size_mask(sz);
    am   = a & m;
    dm   = d & m;
    full = {1'b0, am} - {1'b0, dm};
    diff = full[DW-1:0] & m;
    nib  = {1'b0, am[3:0]} - {1'b0, dm[3:0]};
    f.cf = full[DW];
    f.zf = (diff == '0);
    f.sf = top_bit(diff, sz);
    f.pf = ~^diff[7:0];
    f.af = nib[4];
    f.of = (top_bit(am, sz) != top_bit(dm, sz)) && (top_bit(diff, sz) != top_bit(am, sz));
    return f;
  endfunction

endpackage

// File: rtl/cas_cmp.sv
module cas_cmp
  import cas_pkg::*;
(
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mem_val,
  input  logic [1:0]    size,
  output flags_t        flags,
  output logic [DW-1:0] acc_merged
);

  always_comb begin
    flags      = cmp_flags(acc, mem_val, size);
    acc_merged = merge_low(acc, mem_val, size);
  end

endmodule

// File: rtl/cas_ctrl.sv
module cas_ctrl
  import cas_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic [DW-1:0]     req_acc,
  input  logic [DW-1:0]     req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              match,
  output logic              bus_lock,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic [BEW-1:0]    bus_be,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ack,
  output logic [DW-1:0]     acc_q,
  output logic [DW-1:0]     mem_q,
  output logic [1:0]        size_q,
  output logic              ev_cmp,
  output logic              ev_fin
);

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_CMP, ST_WR, ST_FIN} st_e;

  st_e               st;
  logic [DW-1:0]     src_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ev_accept, ev_rd_ack, ev_wr_ack;

  assign req_ready = (st == ST_IDLE);
  assign ev_accept = req_valid && req_ready;
  assign ev_rd_ack = (st == ST_RD) && bus_ack;
  assign ev_wr_ack = (st == ST_WR) && bus_ack;
  assign ev_cmp    = (st == ST_CMP);
  assign ev_fin    = (st == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      acc_q  <= '0;
      src_q  <= '0;
      mem_q  <= '0;
      addr_q <= '0;
      size_q <= SZ_B;
    end else begin
      case (st)
        ST_IDLE: if (ev_accept) begin
          st     <= ST_RD;
          acc_q  <= req_acc;
          src_q  <= req_src;
          addr_q <= req_addr;
          size_q <= (req_size == 2'd3) ? SZ_W : req_size;
        end
        ST_RD: if (ev_rd_ack) begin
          st    <= ST_CMP;
          mem_q <= bus_rdata;
        end
        ST_CMP: st <= ST_WR;
        ST_WR:  if (ev_wr_ack) st <= ST_FIN;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bus_rd    = (st == ST_RD);
  assign bus_wr    = (st == ST_WR);
  assign bus_lock  = (st == ST_RD) || (st == ST_CMP) || (st == ST_WR);
  assign bus_addr  = addr_q;
  assign bus_be    = size_be(size_q);
  assign bus_wdata = match ? merge_low(mem_q, src_q, size_q) : mem_q;

  AST_REQ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_lock); // R4
  AST_UNLOCK_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> $past(ev_wr_ack)); // R4
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_ack |=> ##1 bus_wr); // R4
  AST_READY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_lock); // R9
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_be[0] && ($countones(bus_be) == 1 || $countones(bus_be) == 2
                              || $countones(bus_be) == 4))); // R5
  AST_MISS_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !match) |-> (bus_wdata == mem_q)); // R3

endmodule

// File: rtl/cas_result.sv
module cas_result
  import cas_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_cmp,
  input  logic          ev_fin,
  input  flags_t        flags_in,
  input  logic [DW-1:0] acc_merged,
  input  logic [DW-1:0] acc_q,
  input  logic [1:0]    size_q,
  output logic          match,
  output flags_t        flags_q,
  output logic [DW-1:0] acc_out,
  output logic          acc_we,
  output logic          done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      acc_out <= '0;
    end else if (ev_cmp) begin
      flags_q <= flags_in;
      acc_out <= flags_in.zf ? acc_q : acc_merged;
    end
  end

  assign match  = flags_q.zf;
  assign done   = ev_fin;
  assign acc_we = ev_fin && !flags_q.zf;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_WE_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> (done && !flags_q.zf)); // R6
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && size_q == SZ_B) |-> (acc_out[31:8] == acc_q[31:8])); // R6
  AST_HIT_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flags_q.zf) |-> (acc_out == acc_q)); // R6

endmodule

// File: rtl/cas_unit.sv
module cas_unit
  import cas_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_acc,
  input  logic [31:0]       req_src,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              bus_lock,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic [3:0]        bus_be,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  output logic [31:0]       acc_out,
  output logic              acc_we,
  output logic              flag_zf,
  output logic              flag_cf,
  output logic              flag_pf,
  output logic              flag_af,
  output logic              flag_sf,
  output logic              flag_of,
  output logic              done
);

  logic [DW-1:0] acc_q, mem_q, acc_merged;
  logic [1:0]    size_q;
  logic          ev_cmp, ev_fin, match;
  flags_t        flags_c, flags_q;

  cas_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_size(req_size),
    .req_acc(req_acc), .req_src(req_src), .req_addr(req_addr),
    .match(match),
    .bus_lock(bus_lock), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .acc_q(acc_q), .mem_q(mem_q), .size_q(size_q),
    .ev_cmp(ev_cmp), .ev_fin(ev_fin)
  );

  cas_cmp u_cmp (
    .acc(acc_q), .mem_val(mem_q), .size(size_q),
    .flags(flags_c), .acc_merged(acc_merged)
  );

  cas_result u_res (
    .clk(clk), .rst_n(rst_n), .ev_cmp(ev_cmp), .ev_fin(ev_fin),
    .flags_in(flags_c), .acc_merged(acc_merged), .acc_q(acc_q), .size_q(size_q),
    .match(match), .flags_q(flags_q), .acc_out(acc_out), .acc_we(acc_we), .done(done)
  );

  assign flag_zf = flags_q.zf;
  assign flag_cf = flags_q.cf;
  assign flag_pf = flags_q.pf;
  assign flag_af = flags_q.af;
  assign flag_sf = flags_q.sf;
  assign flag_of = flags_q.of;

endmodule

// File: tb/cas_unit_tb.sv
`timescale 1ns/1ps
module cas_unit_tb;

  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_size = 2'd0;
  logic [31:0]   req_acc = '0, req_src = '0;
  logic [AW-1:0] req_addr = '0;
  logic          bus_lock, bus_rd, bus_wr, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata, acc_out;
  logic [3:0]    bus_be;
  logic          acc_we, flag_zf, flag_cf, flag_pf, flag_af, flag_sf, flag_of, done;

  cas_unit #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_acc(req_acc), .req_src(req_src), .req_addr(req_addr),
    .bus_lock(bus_lock), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .acc_out(acc_out), .acc_we(acc_we), .flag_zf(flag_zf), .flag_cf(flag_cf),
    .flag_pf(flag_pf), .flag_af(flag_af), .flag_sf(flag_sf), .flag_of(flag_of),
    .done(done)
  );

  // memory model: acknowledge one cycle after each request
  logic [31:0] mem [16];
  logic        pre_we = 1'b0;
  logic [3:0]  pre_idx = '0;
  logic [31:0] pre_val = '0;
  int          rd_cnt = 0, wr_cnt = 0, lock_bad = 0;
  logic [3:0]  last_be = '0;
  logic        ack_r = 1'b0;
  logic [31:0] rdata_r = '0;
  assign bus_ack   = ack_r;
  assign bus_rdata = rdata_r;

  always @(posedge clk) begin
    if (pre_we) mem[pre_idx] <= pre_val;
    ack_r <= (bus_rd || bus_wr) && !ack_r;
    if ((bus_rd || bus_wr) && !bus_lock) lock_bad <= lock_bad + 1;
    if (bus_rd && !ack_r) begin
      rdata_r <= mem[bus_addr[3:0]];
      rd_cnt  <= rd_cnt + 1;
    end
    if (bus_wr && !ack_r) begin
      wr_cnt  <= wr_cnt + 1;
      last_be <= bus_be;
      for (int b = 0; b < 4; b++)
        if (bus_be[b]) mem[bus_addr[3:0]][b*8 +: 8] <= bus_wdata[b*8 +: 8];
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic preload(input int idx, input logic [31:0] v);
    @(negedge clk);
    pre_we = 1'b1; pre_idx = idx[3:0]; pre_val = v;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // one complete operation with all checks; poke drives a competing request while busy
  task automatic run_op(input int sz, input logic [31:0] acc, input logic [31:0] src,
                        input logic [31:0] dest, input int idx, input bit poke);
    longint w, m, a, d, diff, half, sa, sd, tr;
    bit ezf, ecf, esf, eaf, epf, eof;
    longint eacc, emem, ebe;
    int rd0, wr0;
    logic [31:0] other;
    preload(idx, dest);
    other = mem[(idx + 1) % 16];
    rd0 = rd_cnt; wr0 = wr_cnt;
    w    = 64'd8 << sz;
    m    = (64'd1 << w) - 1;
    half = 64'd1 << (w - 1);
    a = longint'(acc) & m;
    d = longint'(dest) & m;
    diff = (a - d) & m;
    ezf = (a == d);
    ecf = (a < d);
    esf = ((diff >> (w - 1)) & 1) != 0;
    eaf = ((a & 15) < (d & 15));
    epf = ($countones(diff & 255) % 2) == 0;
    sa = (a >= half) ? a - (m + 1) : a;
    sd = (d >= half) ? d - (m + 1) : d;
    tr = sa - sd;
    eof = (tr < -half) || (tr >= half);
    eacc = ezf ? longint'(acc) : ((longint'(acc) & ~m & 64'hFFFF_FFFF) | d);
    emem = ezf ? ((longint'(dest) & ~m & 64'hFFFF_FFFF) | (longint'(src) & m)) : longint'(dest);
    ebe  = (sz == 0) ? 1 : (sz == 1) ? 3 : 15;

    @(negedge clk);
    chk(req_ready === 1'b1, "R9 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_size = sz[1:0]; req_acc = acc; req_src = src;
    req_addr = AW'(idx);
    @(posedge clk);
    @(negedge clk);
    if (poke) begin
      req_addr = AW'((idx + 1) % 16); req_acc = ~acc; req_src = ~src;
    end else req_valid = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (poke) chk(req_ready === 1'b0 || k == 5, "R9 ready low while busy", req_ready, 0);
      if (k == 4) chk(done === 1'b0, "R8 done not early", done, 0);
    end
    req_valid = 1'b0;
    chk(done === 1'b1, "R8 done on fifth edge", done, 1);
    chk(flag_zf === ezf, "R1 R2 R3 zero flag", flag_zf, ezf);
    chk(flag_cf === ecf, "R7 carry", flag_cf, ecf);
    chk(flag_sf === esf, "R7 sign", flag_sf, esf);
    chk(flag_af === eaf, "R7 half-carry", flag_af, eaf);
    chk(flag_pf === epf, "R7 parity", flag_pf, epf);
    chk(flag_of === eof, "R7 overflow", flag_of, eof);
    chk(acc_we === !ezf, "R6 acc write-enable", acc_we, !ezf);
    chk(longint'(acc_out) == eacc, "R6 acc value", acc_out, eacc);
    chk(bus_lock === 1'b0, "R4 lock released", bus_lock, 0);
    chk(longint'(mem[idx]) == emem, "R2 R3 memory result", mem[idx], emem);
    chk(rd_cnt - rd0 == 1, "R4 one read", rd_cnt - rd0, 1);
    chk(wr_cnt - wr0 == 1, "R4 one write", wr_cnt - wr0, 1);
    chk(longint'(last_be) == ebe, "R5 byte enables", last_be, ebe);
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R8 done single pulse", done, 0);
    if (poke) chk(mem[(idx + 1) % 16] == other, "R9 busy request ignored",
                  mem[(idx + 1) % 16], other);
  endtask

  function automatic logic [7:0] pat(input int i);
    case (i & 15)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
      4: return 8'h7F;  5: return 8'h80;  6: return 8'h81;  7: return 8'hFE;
      8: return 8'hFF;  9: return 8'h55; 10: return 8'hAA; 11: return 8'h08;
      12: return 8'hF0; 13: return 8'h7E; 14: return 8'h3C; default: return 8'hC3;
    endcase
  endfunction

  function automatic logic [31:0] mkval(input int sz, input int i, input logic [31:0] fill);
    case (sz)
      0: return {fill[31:8], pat(i)};
      1: return {fill[31:16], pat(i), pat(15 - i)};
      default: return {pat(i), pat(15 - i), pat(i ^ 5), pat(i ^ 10)};
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b0 || req_ready === 1'b1, "R9 reset ready known", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 ready after reset", req_ready, 1);
    chk(bus_lock === 1'b0 && bus_rd === 1'b0 && bus_wr === 1'b0, "R4 idle bus after reset",
        {bus_lock, bus_rd, bus_wr}, 0);
    chk(done === 1'b0 && acc_we === 1'b0, "R8 no done after reset", {done, acc_we}, 0);

    // R1: upper bits differ but low bits agree -> match
    run_op(0, 32'hDEAD_BE42, 32'h1111_1199, 32'h0000_0042, 2, 1'b0);
    run_op(1, 32'hCAFE_1234, 32'h5555_ABCD, 32'h7777_1234, 3, 1'b0);
    // R9: competing request during a busy operation
    run_op(2, 32'h1234_5678, 32'h0BAD_F00D, 32'h1234_5679, 4, 1'b1);
    run_op(0, 32'h0000_0080, 32'h0000_0001, 32'hFFFF_FF01, 5, 1'b1);

    // sweep: every width, 16x16 operand patterns, mismatched upper fill
    for (int sz = 0; sz < 3; sz++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          run_op(sz, mkval(sz, i, 32'hA5C3_9E00 ^ (i << 20)),
                 mkval(sz, (i + j) ^ 3, 32'h3C00_7100),
                 mkval(sz, j, 32'h5A17_E600 ^ (j << 24)),
                 (i + j) % 16, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule